// File: doc/BRIEF.md
# Packet Timestamp Event Unit

This block keeps a free-running time counter and turns interesting moments into queued timestamp events. A frame boundary strobe from any receive or transmit port latches the current count into that port's holding slot; the stamp only enters the event queue once a separate packet classifier confirms the frame as a timing packet, and a discard indication throws it away. Rising edges on asynchronous hardware push lines, a software push request, and the counter crossing its midpoint or wrapping to zero also produce events. Software drains the queue one entry at a time and uses the midpoint and wrap markers to extend the count in software. The markers sit in the same queue as the packet stamps, so a late-confirmed packet stamp can appear after a wrap marker although it was taken before the wrap.

A compare register drives a one-shot output pulse of programmable length when the counter reaches the loaded value, which software reloads for each successive pulse (for example once per second). All logic runs on the counter clock; a host write port sets the run and compare-enable controls, the compare value, the pulse width and a counter preset.

Top module: `pkt_tstamp_unit`

## Requirements
- R1: After reset the counter reads 0 and is stopped; with the run bit (control word bit 0, address 0) set it advances by exactly one per clock, and a write to address 3 presets it to the written value on the next edge.
- R2: When the counter steps from all ones to zero, an event of kind 4 with stamp 0 and source 0 is queued.
- R3: When the counter steps from 0x7FFF_FFFF to 0x8000_0000, an event of kind 5 with stamp 0x8000_0000 and source 0 is queued.
- R4: A strobe on frame slot s (slots 0..NPORT-1 are receive ports, NPORT..2*NPORT-1 transmit ports) latches the counter value of that cycle; a later confirm on slot s queues kind 2 (receive) or kind 3 (transmit) with source equal to the port number s mod NPORT; nothing is queued before the confirm.
- R5: A discard on a slot drops its held stamp so a following confirm queues nothing; a confirm on an empty slot is ignored; a new strobe replaces an unconfirmed stamp.
- R6: A rising edge on hardware push line n queues exactly one event of kind 1, source n, stamped with the counter value SYNC_N cycles after the line rose, however long the line stays high.
- R7: Writing address 0 with bit 2 set queues an event of kind 0, source 0, stamped with the counter value of the write cycle.
- R8: Events arising in the same cycle are queued one per cycle in fixed order: wrap, midpoint, receive slots by ascending port, transmit slots by ascending port, hardware lines by ascending number, software push; waiting events keep their stamps.
- R9: The queue returns entries in arrival order and holds DEPTH entries; an event granted while it is full is dropped and sets a sticky overflow flag, which a write to address 0 with bit 3 set clears.
- R10: With compare enabled (control bit 1), once the counter equals the value last written to address 1, the pulse output rises on the next edge and stays high for the width written to address 2 (0 counts as 1), and fires only once per compare write.
- R11: With compare enable clear, the pulse output never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register select: 0 control, 1 compare, 2 pulse width, 3 counter preset |
| host_wdata | input | TIME_W (32) | Host write data |
| sfd_stb | input | 2*NPORT (8) | Frame boundary strobe per slot |
| pkt_ok | input | 2*NPORT (8) | Classifier confirm per slot |
| pkt_bad | input | 2*NPORT (8) | Classifier discard per slot |
| hw_push | input | NHW (8) | Asynchronous hardware push lines |
| evt_pop | input | 1 | Remove the head entry |
| time_now | output | TIME_W (32) | Current counter value |
| cmp_pulse | output | 1 | Compare pulse |
| evt_valid | output | 1 | Queue holds at least one entry |
| evt_type | output | 3 | Head entry kind |
| evt_src | output | SRC_W (3) | Head entry port or line number |
| evt_stamp | output | TIME_W (32) | Head entry stamp |
| ovf_flag | output | 1 | Sticky lost-event flag |

## Verification
The bench sweeps every frame slot and every hardware line and checks kind, source and stamp, so a swapped receive/transmit mapping or an off-by-one synchronizer latency shows up as a wrong field. It presets the counter just below the midpoint and the wrap, and confirms a stamp taken before the wrap only after the wrap, so a design that committed at the strobe or stamped markers with the wrong value would misorder or misstamp entries. Simultaneous confirms, a hardware edge and a software push land in one cycle to expose a wrong priority or a lost waiter, nine pushes into an eight-deep queue expose a missing drop or a non-sticky flag, and a sweep of pulse widths catches a pulse that starts a cycle early, lasts the wrong length, repeats, or fires while disabled.

// File: rtl/ptsu_pkg.sv
package ptsu_pkg;
   typedef enum logic [2:0] {
      EV_SW   = 3'd0,
      EV_HW   = 3'd1,
      EV_RX   = 3'd2,
      EV_TX   = 3'd3,
      EV_WRAP = 3'd4,
      EV_MID  = 3'd5
   } ev_kind_e;

   localparam int KIND_W = 3;
endpackage

// File: rtl/ptsu_pend.sv
module ptsu_pend #(
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set,
   input  logic [TIME_W-1:0] stamp_in,
   input  logic              grant,
   output logic              req,
   output logic [TIME_W-1:0] stamp,
   output logic              lost
);
   // an event arriving while the previous one still waits replaces it
   assign lost = set && req && !grant;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req   <= 1'b0;
         stamp <= '0;
      end else if (set) begin
         req   <= 1'b1;
         stamp <= stamp_in;
      end else if (grant) begin
         req   <= 1'b0;
      end
   end

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req && !grant && !set |=> req && $stable(stamp)); // R8
endmodule

// File: rtl/ptsu_sfd_slot.sv
module ptsu_sfd_slot #(
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic              ok,
   input  logic              bad,
   input  logic [TIME_W-1:0] time_now,
   input  logic              grant,
   output logic              req,
   output logic [TIME_W-1:0] stamp,
   output logic              lost
);
   logic              held;
   logic [TIME_W-1:0] held_stamp;
   logic              commit;

   // confirm and discard act on the stamp held before this cycle's strobe
   assign commit = ok && held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held       <= 1'b0;
         held_stamp <= '0;
      end else if (stb) begin
         held       <= 1'b1;
         held_stamp <= time_now;
      end else if (ok || bad) begin
         held       <= 1'b0;
      end
   end

   ptsu_pend #(.TIME_W(TIME_W)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (commit),
      .stamp_in (held_stamp),
      .grant    (grant),
      .req      (req),
      .stamp    (stamp),
      .lost     (lost)
   );

   AST_DISCARD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      bad && !stb |=> !held); // R5
   AST_NO_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      ok && !held && !req |=> !req); // R5
endmodule

// File: rtl/ptsu_hw_push.sv
module ptsu_hw_push #(
   parameter int TIME_W = 32,
   parameter int SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              async_in,
   input  logic [TIME_W-1:0] time_now,
   input  logic              grant,
   output logic              req,
   output logic [TIME_W-1:0] stamp,
   output logic              lost
);
   logic [SYNC_N-1:0] sh;
   logic              prev;
   logic              rise;

   if (SYNC_N < 2) begin : g_bad_sync
      $error("ptsu_hw_push: SYNC_N must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         prev <= 1'b0;
      end else begin
         sh   <= {sh[SYNC_N-2:0], async_in};
         prev <= sh[SYNC_N-1];
      end
   end

   assign rise = sh[SYNC_N-1] && !prev;

   ptsu_pend #(.TIME_W(TIME_W)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (rise),
      .stamp_in (time_now),
      .grant    (grant),
      .req      (req),
      .stamp    (stamp),
      .lost     (lost)
   );

   AST_ONE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R6
endmodule

// File: rtl/ptsu_time_base.sv
module ptsu_time_base #(
   parameter int TIME_W = 32,
   parameter int PW_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              ld,
   input  logic [TIME_W-1:0] ld_val,
   input  logic              cmp_en,
   input  logic              cmp_wr,
   input  logic [TIME_W-1:0] cmp_wval,
   input  logic [PW_W-1:0]   pw,
   output logic [TIME_W-1:0] time_q,
   output logic              wrap_evt,
   output logic              mid_evt,
   output logic              cmp_pulse
);
   localparam logic [TIME_W-1:0] ALL_ONES = '1;
   localparam logic [TIME_W-1:0] MID_LAST = {1'b0, {(TIME_W-1){1'b1}}};

   logic [TIME_W-1:0] cmp_val;
   logic              armed;
   logic              fire;
   logic [PW_W-1:0]   pcnt;

   assign wrap_evt = run && !ld && (time_q == ALL_ONES);
   assign mid_evt  = run && !ld && (time_q == MID_LAST);
   assign fire     = cmp_en && armed && (time_q == cmp_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       time_q <= '0;
      else if (ld)      time_q <= ld_val;
      else if (run)     time_q <= time_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_val <= '0;
         armed   <= 1'b0;
      end else if (cmp_wr) begin
         cmp_val <= cmp_wval;
         armed   <= 1'b1;
      end else if (fire) begin
         armed   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pcnt <= '0;
      else if (fire)        pcnt <= (pw == '0) ? PW_W'(1) : pw;
      else if (pcnt != '0)  pcnt <= pcnt - 1'b1;
   end

   assign cmp_pulse = (pcnt != '0);

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      run && !ld |=> time_q == $past(time_q) + 1'b1); // R1
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |=> time_q == '0); // R2
   AST_MID_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      mid_evt |=> time_q[TIME_W-1] && (time_q[TIME_W-2:0] == '0)); // R3
   AST_PULSE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_pulse) |-> $past(cmp_en)); // R11
endmodule

// File: rtl/ptsu_evt_queue.sv
module ptsu_evt_queue #(
   parameter int NSRC   = 4,
   parameter int TIME_W = 32,
   parameter int SRC_W  = 3,
   parameter int DEPTH  = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NSRC-1:0]              req,
   input  logic [NSRC-1:0][TIME_W-1:0]  stamp,
   input  logic [NSRC-1:0][2:0]         kind,
   input  logic [NSRC-1:0][SRC_W-1:0]   srcidx,
   input  logic                         lost_any,
   input  logic                         ovf_clr,
   input  logic                         pop,
   output logic [NSRC-1:0]              grant,
   output logic                         head_valid,
   output logic [2:0]                   head_kind,
   output logic [SRC_W-1:0]             head_src,
   output logic [TIME_W-1:0]            head_stamp,
   output logic                         ovf
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int EW = 3 + SRC_W + TIME_W;

   logic [EW-1:0] mem [DEPTH];
   logic [EW-1:0] sel_ent;
   logic [EW-1:0] head_ent;
   logic          hit;
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [AW:0]   cnt;
   logic          full, do_push, do_pop, drop;

   if (DEPTH < 2) begin : g_bad_depth
      $error("ptsu_evt_queue: DEPTH must be at least 2");
   end

   // fixed priority: lowest source index wins
   always_comb begin
      grant   = '0;
      hit     = 1'b0;
      sel_ent = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (req[i] && !hit) begin
            grant[i] = 1'b1;
            hit      = 1'b1;
            sel_ent  = {kind[i], srcidx[i], stamp[i]};
         end
      end
   end

   if ((1 << AW) == DEPTH) begin : g_pow2
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
   end else begin : g_mod
      assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   assign full    = (cnt == (AW+1)'(DEPTH));
   assign do_push = hit && !full;
   assign drop    = hit && full;
   assign do_pop  = pop && (cnt != '0);

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= sel_ent;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         if (drop || lost_any) ovf <= 1'b1;
         else if (ovf_clr)     ovf <= 1'b0;
      end
   end

   assign head_ent   = mem[rp];
   assign head_valid = (cnt != '0);
   assign head_kind  = head_ent[EW-1 -: 3];
   assign head_src   = head_ent[TIME_W +: SRC_W];
   assign head_stamp = head_ent[TIME_W-1:0];

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (AW+1)'(DEPTH)); // R9
   AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> ovf); // R9
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf && !ovf_clr |=> ovf); // R9
endmodule

// File: rtl/pkt_tstamp_unit.sv
module pkt_tstamp_unit #(
   parameter int  NPORT  = 4,
   parameter int  NHW    = 8,
   parameter int  TIME_W = 32,
   parameter int  DEPTH  = 8,
   parameter int  PW_W   = 8,
   parameter int  SYNC_N = 2,
   localparam int NSLOT  = 2 * NPORT,
   localparam int MAXN   = (NPORT > NHW) ? NPORT : NHW,
   localparam int SRC_W  = (MAXN > 1) ? $clog2(MAXN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [1:0]        host_addr,
   input  logic [TIME_W-1:0] host_wdata,
   input  logic [NSLOT-1:0]  sfd_stb,
   input  logic [NSLOT-1:0]  pkt_ok,
   input  logic [NSLOT-1:0]  pkt_bad,
   input  logic [NHW-1:0]    hw_push,
   input  logic              evt_pop,
   output logic [TIME_W-1:0] time_now,
   output logic              cmp_pulse,
   output logic              evt_valid,
   output logic [2:0]        evt_type,
   output logic [SRC_W-1:0]  evt_src,
   output logic [TIME_W-1:0] evt_stamp,
   output logic              ovf_flag
);
   import ptsu_pkg::*;

   localparam int NSRC     = 3 + NSLOT + NHW;
   localparam int IDX_WRAP = 0;
   localparam int IDX_MID  = 1;
   localparam int IDX_SLOT = 2;
   localparam int IDX_HW   = IDX_SLOT + NSLOT;
   localparam int IDX_SW   = NSRC - 1;
   localparam logic [TIME_W-1:0] MID_STAMP = {1'b1, {(TIME_W-1){1'b0}}};

   if (NPORT < 1 || NHW < 1) begin : g_bad_counts
      $error("pkt_tstamp_unit: NPORT and NHW must be at least 1");
   end
   if (PW_W > TIME_W || TIME_W < 4) begin : g_bad_widths
      $error("pkt_tstamp_unit: PW_W must fit in TIME_W, TIME_W >= 4");
   end

   // host register file
   logic            run_q, cmpen_q;
   logic [PW_W-1:0] pw_q;
   logic            wr_ctl, wr_cmp, wr_pw, wr_ld;
   logic            sw_push, ovf_clr;

   assign wr_ctl  = host_we && (host_addr == 2'd0);
   assign wr_cmp  = host_we && (host_addr == 2'd1);
   assign wr_pw   = host_we && (host_addr == 2'd2);
   assign wr_ld   = host_we && (host_addr == 2'd3);
   assign sw_push = wr_ctl && host_wdata[2];
   assign ovf_clr = wr_ctl && host_wdata[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         cmpen_q <= 1'b0;
         pw_q    <= '0;
      end else begin
         if (wr_ctl) begin
            run_q   <= host_wdata[0];
            cmpen_q <= host_wdata[1];
         end
         if (wr_pw) pw_q <= host_wdata[PW_W-1:0];
      end
   end

   logic wrap_evt, mid_evt;

   ptsu_time_base #(.TIME_W(TIME_W), .PW_W(PW_W)) u_time (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_q),
      .ld        (wr_ld),
      .ld_val    (host_wdata),
      .cmp_en    (cmpen_q),
      .cmp_wr    (wr_cmp),
      .cmp_wval  (host_wdata),
      .pw        (pw_q),
      .time_q    (time_now),
      .wrap_evt  (wrap_evt),
      .mid_evt   (mid_evt),
      .cmp_pulse (cmp_pulse)
   );

   // event sources, indexed in priority order
   logic [NSRC-1:0]             req, grant, lost;
   logic [NSRC-1:0][TIME_W-1:0] st;
   logic [NSRC-1:0][2:0]        kd;
   logic [NSRC-1:0][SRC_W-1:0]  sx;

   ptsu_pend #(.TIME_W(TIME_W)) u_wrap (
      .clk (clk), .rst_n (rst_n), .set (wrap_evt), .stamp_in ('0),
      .grant (grant[IDX_WRAP]), .req (req[IDX_WRAP]),
      .stamp (st[IDX_WRAP]), .lost (lost[IDX_WRAP])
   );
   assign kd[IDX_WRAP] = EV_WRAP;
   assign sx[IDX_WRAP] = '0;

   ptsu_pend #(.TIME_W(TIME_W)) u_mid (
      .clk (clk), .rst_n (rst_n), .set (mid_evt), .stamp_in (MID_STAMP),
      .grant (grant[IDX_MID]), .req (req[IDX_MID]),
      .stamp (st[IDX_MID]), .lost (lost[IDX_MID])
   );
   assign kd[IDX_MID] = EV_MID;
   assign sx[IDX_MID] = '0;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      ptsu_sfd_slot #(.TIME_W(TIME_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .stb      (sfd_stb[s]),
         .ok       (pkt_ok[s]),
         .bad      (pkt_bad[s]),
         .time_now (time_now),
         .grant    (grant[IDX_SLOT+s]),
         .req      (req[IDX_SLOT+s]),
         .stamp    (st[IDX_SLOT+s]),
         .lost     (lost[IDX_SLOT+s])
      );
      assign kd[IDX_SLOT+s] = (s < NPORT) ? EV_RX : EV_TX;
      assign sx[IDX_SLOT+s] = SRC_W'(s % NPORT);
   end

   for (genvar h = 0; h < NHW; h++) begin : g_hw
      ptsu_hw_push #(.TIME_W(TIME_W), .SYNC_N(SYNC_N)) u_hw (
         .clk      (clk),
         .rst_n    (rst_n),
         .async_in (hw_push[h]),
         .time_now (time_now),
         .grant    (grant[IDX_HW+h]),
         .req      (req[IDX_HW+h]),
         .stamp    (st[IDX_HW+h]),
         .lost     (lost[IDX_HW+h])
      );
      assign kd[IDX_HW+h] = EV_HW;
      assign sx[IDX_HW+h] = SRC_W'(h);
   end

   ptsu_pend #(.TIME_W(TIME_W)) u_sw (
      .clk (clk), .rst_n (rst_n), .set (sw_push), .stamp_in (time_now),
      .grant (grant[IDX_SW]), .req (req[IDX_SW]),
      .stamp (st[IDX_SW]), .lost (lost[IDX_SW])
   );
   assign kd[IDX_SW] = EV_SW;
   assign sx[IDX_SW] = '0;

   ptsu_evt_queue #(
      .NSRC (NSRC), .TIME_W (TIME_W), .SRC_W (SRC_W), .DEPTH (DEPTH)
   ) u_queue (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req),
      .stamp      (st),
      .kind       (kd),
      .srcidx     (sx),
      .lost_any   (|lost),
      .ovf_clr    (ovf_clr),
      .pop        (evt_pop),
      .grant      (grant),
      .head_valid (evt_valid),
      .head_kind  (evt_type),
      .head_src   (evt_src),
      .head_stamp (evt_stamp),
      .ovf        (ovf_flag)
   );
endmodule

// File: tb/pkt_tstamp_unit_tb.sv
module pkt_tstamp_unit_tb;
   localparam int CLK_P = 10;
   localparam logic [31:0] RUN = 32'h1, CMPEN = 32'h2, SWP = 32'h4, CLR = 32'h8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [1:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [7:0]  sfd_stb = '0, pkt_ok = '0, pkt_bad = '0, hw_push = '0;
   logic        evt_pop = 1'b0;
   logic [31:0] time_now, evt_stamp;
   logic        cmp_pulse, evt_valid, ovf_flag;
   logic [2:0]  evt_type, evt_src;

   int nchk = 0;
   int nerr = 0;

   always #(CLK_P/2) clk = ~clk;

   pkt_tstamp_unit u_dut (
      .clk (clk), .rst_n (rst_n), .host_we (host_we), .host_addr (host_addr),
      .host_wdata (host_wdata), .sfd_stb (sfd_stb), .pkt_ok (pkt_ok),
      .pkt_bad (pkt_bad), .hw_push (hw_push), .evt_pop (evt_pop),
      .time_now (time_now), .cmp_pulse (cmp_pulse), .evt_valid (evt_valid),
      .evt_type (evt_type), .evt_src (evt_src), .evt_stamp (evt_stamp),
      .ovf_flag (ovf_flag)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   // kinds: 0 sw, 1 hw, 2 rx, 3 tx, 4 wrap, 5 midpoint
   task automatic take(input logic [2:0] k, input int src,
                       input logic [31:0] st, input string req);
      check(req, "valid", 64'(evt_valid), 64'd1);
      check(req, "kind",  64'(evt_type), 64'(k));
      check(req, "src",   64'(evt_src), 64'(src));
      check(req, "stamp", 64'(evt_stamp), 64'(st));
      evt_pop = 1'b1;
      @(negedge clk);
      evt_pop = 1'b0;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   initial begin
      #(CLK_P * 150000);
      nerr++;
      $display("FAIL R1 watchdog: actual=timeout expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] t, t2, th, ts, c;
      logic [31:0] fill [9];
      int ws [5] = '{0, 1, 2, 3, 5};

      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      check("R1", "reset time", 64'(time_now), 64'd0);
      check("R1", "reset valid", 64'(evt_valid), 64'd0);
      check("R1", "reset pulse", 64'(cmp_pulse), 64'd0);
      check("R1", "reset ovf", 64'(ovf_flag), 64'd0);
      cyc(3);
      check("R1", "stopped", 64'(time_now), 64'd0);
      wr(2'd0, RUN);
      t = time_now;
      cyc(5);
      check("R1", "advance", 64'(time_now), 64'(t + 32'd5));
      wr(2'd3, 32'h1234);
      check("R1", "preset", 64'(time_now), 64'h1234);

      // R7 software push
      t = time_now;
      wr(2'd0, RUN | SWP);
      cyc(2);
      take(3'd0, 0, t, "R7");

      // R4 sweep over all frame slots
      for (int s = 0; s < 8; s++) begin
         sfd_stb[s] = 1'b1;
         t = time_now;
         cyc(1);
         sfd_stb[s] = 1'b0;
         cyc(2);
         check("R4", "held before confirm", 64'(evt_valid), 64'd0);
         pkt_ok[s] = 1'b1;
         cyc(1);
         pkt_ok[s] = 1'b0;
         cyc(2);
         take((s < 4) ? 3'd2 : 3'd3, s % 4, t, "R4");
      end

      // R5 discard, confirm on empty slot, overwrite
      sfd_stb[1] = 1'b1; cyc(1); sfd_stb[1] = 1'b0; cyc(1);
      pkt_bad[1] = 1'b1; cyc(1); pkt_bad[1] = 1'b0; cyc(1);
      pkt_ok[1] = 1'b1;  cyc(1); pkt_ok[1] = 1'b0;  cyc(3);
      check("R5", "discarded", 64'(evt_valid), 64'd0);
      sfd_stb[2] = 1'b1; cyc(1); sfd_stb[2] = 1'b0; cyc(2);
      sfd_stb[2] = 1'b1; t2 = time_now; cyc(1); sfd_stb[2] = 1'b0; cyc(1);
      pkt_ok[2] = 1'b1;  cyc(1); pkt_ok[2] = 1'b0;  cyc(2);
      take(3'd2, 2, t2, "R5");
      check("R5", "single entry", 64'(evt_valid), 64'd0);

      // R6 sweep over hardware lines, held high for several cycles
      for (int n = 0; n < 8; n++) begin
         hw_push[n] = 1'b1;
         t = time_now;
         cyc(5);
         hw_push[n] = 1'b0;
         cyc(4);
         take(3'd1, n, t + 32'd2, "R6");
         check("R6", "one event", 64'(evt_valid), 64'd0);
      end

      // R3 midpoint, R2 wrap
      wr(2'd3, 32'h7FFF_FFFC);
      cyc(8);
      take(3'd5, 0, 32'h8000_0000, "R3");
      check("R3", "only marker", 64'(evt_valid), 64'd0);
      wr(2'd3, 32'hFFFF_FFFC);
      cyc(8);
      take(3'd4, 0, 32'h0, "R2");
      check("R2", "only marker", 64'(evt_valid), 64'd0);

      // R2/R4 stamp taken before wrap, confirmed after it
      wr(2'd3, 32'hFFFF_FFFA);
      sfd_stb[1] = 1'b1;
      t = time_now;
      cyc(1);
      sfd_stb[1] = 1'b0;
      cyc(8);
      pkt_ok[1] = 1'b1; cyc(1); pkt_ok[1] = 1'b0; cyc(2);
      take(3'd4, 0, 32'h0, "R2");
      take(3'd2, 1, t, "R4");

      // R8 simultaneous events
      sfd_stb[0] = 1'b1; sfd_stb[5] = 1'b1;
      t = time_now;
      cyc(1);
      sfd_stb = '0;
      cyc(2);
      hw_push[3] = 1'b1;
      th = time_now;
      cyc(2);
      pkt_ok[0] = 1'b1; pkt_ok[5] = 1'b1;
      host_we = 1'b1; host_addr = 2'd0; host_wdata = RUN | SWP;
      ts = time_now;
      cyc(1);
      pkt_ok = '0; host_we = 1'b0;
      cyc(6);
      hw_push[3] = 1'b0;
      take(3'd2, 0, t, "R8");
      take(3'd3, 1, t, "R8");
      take(3'd1, 3, th + 32'd2, "R8");
      take(3'd0, 0, ts, "R8");
      check("R8", "drained", 64'(evt_valid), 64'd0);
      cyc(4);

      // R9 fill, overflow, order, clear
      for (int i = 0; i < 9; i++) begin
         fill[i] = time_now;
         wr(2'd0, RUN | SWP);
         cyc(1);
         if (i == 7) check("R9", "no flag at full", 64'(ovf_flag), 64'd0);
      end
      check("R9", "overflow flag", 64'(ovf_flag), 64'd1);
      for (int i = 0; i < 8; i++) take(3'd0, 0, fill[i], "R9");
      check("R9", "ninth dropped", 64'(evt_valid), 64'd0);
      check("R9", "flag sticky", 64'(ovf_flag), 64'd1);
      wr(2'd0, RUN | CLR);
      check("R9", "flag cleared", 64'(ovf_flag), 64'd0);

      // R10 compare pulse over several widths
      wr(2'd0, RUN | CMPEN);
      for (int k = 0; k < 5; k++) begin
         int hi;
         bit seen;
         wr(2'd2, 32'(ws[k]));
         c = time_now + 32'd12;
         wr(2'd1, c);
         hi = 0;
         seen = 1'b0;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cmp_pulse) begin
               if (!seen) check("R10", "pulse start", 64'(time_now), 64'(c + 32'd1));
               seen = 1'b1;
               hi++;
            end
         end
         check("R10", "pulse length", 64'(hi), 64'((ws[k] == 0) ? 1 : ws[k]));
      end

      // R11 compare disabled
      begin
         int hi;
         wr(2'd0, RUN);
         c = time_now + 32'd8;
         wr(2'd1, c);
         hi = 0;
         for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (cmp_pulse) hi++;
         end
         check("R11", "no pulse", 64'(hi), 64'd0);
      end

      summary();
      $finish;
   end
endmodule